// File: doc/BRIEF.md
# Multichannel DAC Command Register Controller

This block is the digital core of a 32-channel voltage-output converter. A host sends it 32-bit command words over a three-wire serial link. Each word is framed by an active-low chip select and shifted in most significant bit first. The block decodes a 3-bit opcode and a 6-bit target address from each word. It keeps two 16-bit registers for every channel: a staging register and a live register. The live register drives the converter. An extra offset channel and a configuration word are kept in the same way.

All live registers are exposed as parallel buses. Two active-low pins act directly on the register banks. One copies all staged values to the live registers. The other wipes every register. A read command loads a reply word, and the reply is shifted out on the serial output during the following frame.

The serial link is oversampled by the system clock. A frame counts only if chip select rises after exactly 32 serial clock rising edges. Every clear starts a protected window. Frames that overlap that window are thrown away.

Top module: `mcdac_ctrl`

Word layout, bit 31 first: opcode [31:29], address [28:23], ignored [22:16], data [15:0]. Opcodes: 000 no-op, 001 stage, 010 publish, 011 write-through, 100 read, 101/110 reserved, 111 clear. Addresses: 0..31 one channel, 32 offset channel, 33 configuration, 63 all 32 channels.

## Requirements
- R1: After reset, every live register, the offset live register, `dout` and `busy` are all zero.
- R2: Opcode 001 writes the data field into the staging register of the addressed channel or of the offset channel. The live registers do not change.
- R3: Opcode 010 copies staging into live. A single channel or the offset channel is updated when addressed. Address 63 updates all 32 channels and leaves the offset live register unchanged.
- R4: Opcode 011 writes the data field into both the staging and the live register of the addressed target. With address 63 the target is all 32 channels but not the offset channel.
- R5: Opcode 001 or 011 with address 33 writes the configuration word, and opcode 100 with address 33 returns it.
- R6: Opcode 100 loads the reply {opcode, address, 7'b0, value} into the output shifter, and it is shifted out MSB first during the next frame. The value is the addressed live register, the offset live register (address 32) or the configuration word (address 33). Any other address gives a value of zero.
- R7: Opcodes 000, 101 and 110 change no register.
- R8: Opcode 111 zeroes the staging and live registers of the addressed channel, or of all 32 channels for address 63. The offset channel is never touched by it. `busy` rises right after the frame.
- R9: While `ldac_n` is low, every channel's live register takes its staging value. The offset channel is not affected.
- R10: While `clr_n` is low, every staging register, live register (offset included) and the configuration word is held at zero.
- R11: After a clear, `busy` stays high for CLR_HOLD cycles. Any frame that overlaps this window is discarded.
- R12: A frame that ends with any count of serial clock rising edges other than 32 is discarded.
- R13: Opcode 001 with address 63 stages the data into all 32 channels but not into the offset channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial command data, MSB first |
| ldac_n | input | 1 | Active-low load of all channel live registers |
| clr_n | input | 1 | Active-low clear of every register |
| dout | output | 1 | Serial reply, MSB first |
| busy | output | 1 | High during a clear and its protected window |
| dac_q | output | NCH*DW | Live registers, channel k at bits [k*DW +: DW] |
| offset_q | output | DW | Live register of the offset channel |

## Verification
The hardest case to reach is a frame that arrives while a clear is still protected. The protection window is longer than a full frame. So the stimulus sends a clear command and then, without waiting, sends a write-through to the channel that was just cleared. The channel must still read zero once `busy` drops. Two other cases are reached the same way. One is a frame cut one edge short or run one edge long. The other is a hardware load pulse issued while an offset value is staged but not yet published. Both are checked at the live output buses.

// File: rtl/mcdac_pkg.sv
package mcdac_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 6;
  localparam int OP_W    = 3;
  localparam int PAD_W   = 7;
  localparam int FIELD_W = 16;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'b000,
    OP_STAGE = 3'b001,
    OP_PUB   = 3'b010,
    OP_WTHRU = 3'b011,
    OP_READ  = 3'b100,
    OP_RSV5  = 3'b101,
    OP_RSV6  = 3'b110,
    OP_CLEAR = 3'b111
  } op_e;

  localparam logic [ADDR_W-1:0] ADR_OFFSET = 6'd32;
  localparam logic [ADDR_W-1:0] ADR_CFG    = 6'd33;
  localparam logic [ADDR_W-1:0] ADR_ALL    = 6'd63;

  function automatic op_e word_op(input logic [FRAME_W-1:0] w);
    return op_e'(w[FRAME_W-1 -: OP_W]);
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-OP_W-1 -: ADDR_W];
  endfunction

  function automatic logic [FRAME_W-1:0] make_word(input op_e op,
                                                   input logic [ADDR_W-1:0] a,
                                                   input logic [FIELD_W-1:0] d);
    return {op, a, {PAD_W{1'b0}}, d};
  endfunction

  // Does address a select register slot idx (the offset slot if is_off)?
  function automatic logic addr_hits(input logic [ADDR_W-1:0] a, input int idx,
                                     input logic is_off);
    if (is_off) return a == ADR_OFFSET;
    return (a == ADR_ALL) || (a == ADDR_W'(idx));
  endfunction
endpackage

// File: rtl/mcdac_serial.sv
module mcdac_serial #(
  parameter int FW = 32,
  parameter int CW = $clog2(FW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          din,
  input  logic          hold,
  input  logic          ld_tx,
  input  logic [FW-1:0] tx_word,
  output logic          frm_valid,
  output logic [FW-1:0] frm_word,
  output logic          cs_rise,
  output logic [CW-1:0] bit_cnt,
  output logic          dout
);
  logic          sclk_d, cs_d, spoiled, sclk_rise;
  logic [FW-1:0] rx_sh, tx_sh;

  assign sclk_rise = sclk & ~sclk_d & ~cs_n;
  assign cs_rise   = cs_n & ~cs_d;
  assign frm_valid = cs_rise && !spoiled && !hold && (bit_cnt == CW'(FW));
  assign frm_word  = rx_sh;
  assign dout      = tx_sh[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      spoiled <= 1'b0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (cs_n) bit_cnt <= '0;
      else if (sclk_rise && bit_cnt != CW'(FW + 1)) bit_cnt <= bit_cnt + 1'b1;
      if (sclk_rise) rx_sh <= {rx_sh[FW-2:0], din};
      if (hold) spoiled <= 1'b1;
      else if (cs_n) spoiled <= 1'b0;
      if (ld_tx) tx_sh <= tx_word;
      else if (sclk_rise) tx_sh <= {tx_sh[FW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mcdac_clrctl.sv
module mcdac_clrctl #(
  parameter int CLR_HOLD = 200,
  parameter int HW       = $clog2(CLR_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic sw_clr,
  output logic hw_clr,
  output logic busy
);
  logic [HW-1:0] hold_cnt;

  assign hw_clr = ~clr_n;
  assign busy   = hw_clr || (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_cnt <= '0;
    else if (hw_clr || sw_clr) hold_cnt <= HW'(CLR_HOLD);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end
endmodule

// File: rtl/mcdac_regbank.sv
module mcdac_regbank
  import mcdac_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [FRAME_W-1:0] cmd_word,
  input  logic               ldac_req,
  input  logic               hw_clr,
  output logic [NCH*DW-1:0]  chan_dac,
  output logic [NCH*DW-1:0]  chan_inp,
  output logic [DW-1:0]      off_dac,
  output logic [FRAME_W-1:0] rd_word
);
  localparam int SLOTS = NCH + 1;

  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     data, cfg_q, rd_val;
  logic [FIELD_W-1:0] rd_wide;
  logic [SLOTS*DW-1:0] dac_all, inp_all;

  assign op   = word_op(cmd_word);
  assign addr = word_addr(cmd_word);
  assign data = cmd_word[DW-1:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam logic IS_OFF = (g == NCH);
    logic          sel;
    logic [DW-1:0] inp_q, dac_q, inp_n, dac_n;

    assign sel = cmd_valid && addr_hits(addr, g, IS_OFF);

    always_comb begin
      inp_n = inp_q;
      dac_n = dac_q;
      if (!IS_OFF && ldac_req) dac_n = inp_q;
      if (sel) begin
        case (op)
          OP_STAGE: inp_n = data;
          OP_PUB:   dac_n = inp_q;
          OP_WTHRU: begin inp_n = data; dac_n = data; end
          OP_CLEAR: if (!IS_OFF) begin inp_n = '0; dac_n = '0; end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inp_q <= '0;
        dac_q <= '0;
      end else if (hw_clr) begin
        inp_q <= '0;
        dac_q <= '0;
      end else begin
        inp_q <= inp_n;
        dac_q <= dac_n;
      end
    end

    assign dac_all[g*DW +: DW] = dac_q;
    assign inp_all[g*DW +: DW] = inp_q;
  end

  assign chan_dac = dac_all[NCH*DW-1:0];
  assign chan_inp = inp_all[NCH*DW-1:0];
  assign off_dac  = dac_all[NCH*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (hw_clr) cfg_q <= '0;
    else if (cmd_valid && addr == ADR_CFG) begin
      if (op == OP_STAGE || op == OP_WTHRU) cfg_q <= data;
      else if (op == OP_CLEAR) cfg_q <= '0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (int'(addr) < NCH) rd_val = dac_all[int'(addr)*DW +: DW];
    else if (addr == ADR_OFFSET) rd_val = off_dac;
    else if (addr == ADR_CFG) rd_val = cfg_q;
    rd_wide = '0;
    rd_wide[DW-1:0] = rd_val;
  end

  assign rd_word = make_word(op, addr, rd_wide);
endmodule

// File: rtl/mcdac_ctrl.sv
module mcdac_ctrl
  import mcdac_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int DW       = 16,
  parameter int CLR_HOLD = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic              dout,
  output logic              busy,
  output logic [NCH*DW-1:0] dac_q,
  output logic [DW-1:0]     offset_q
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic               frm_valid, cs_rise, hw_clr, sw_clr, rd_load;
  logic [FRAME_W-1:0] frm_word, rd_word;
  logic [CNT_W-1:0]   bit_cnt;
  logic [NCH*DW-1:0]  inp_flat;
  op_e                frm_op;

  assign frm_op  = word_op(frm_word);
  assign sw_clr  = frm_valid && (frm_op == OP_CLEAR);
  assign rd_load = frm_valid && (frm_op == OP_READ);

  mcdac_serial #(.FW(FRAME_W), .CW(CNT_W)) u_serial (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .hold(busy), .ld_tx(rd_load), .tx_word(rd_word),
    .frm_valid(frm_valid), .frm_word(frm_word), .cs_rise(cs_rise),
    .bit_cnt(bit_cnt), .dout(dout)
  );

  mcdac_clrctl #(.CLR_HOLD(CLR_HOLD)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sw_clr(sw_clr),
    .hw_clr(hw_clr), .busy(busy)
  );

  mcdac_regbank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(frm_valid), .cmd_word(frm_word),
    .ldac_req(~ldac_n), .hw_clr(hw_clr),
    .chan_dac(dac_q), .chan_inp(inp_flat), .off_dac(offset_q), .rd_word(rd_word)
  );
endmodule

// File: rtl/mcdac_ctrl_chk.sv
module mcdac_ctrl_chk #(
  parameter int NCH = 32,
  parameter int DW  = 16,
  parameter int CW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              ldac_n,
  input logic              busy,
  input logic              frm_valid,
  input logic [31:0]       frm_word,
  input logic              cs_rise,
  input logic [CW-1:0]     bit_cnt,
  input logic [NCH*DW-1:0] dac_q,
  input logic [NCH*DW-1:0] inp_flat,
  input logic [DW-1:0]     offset_q
);
  logic [2:0] op;
  logic [5:0] addr;
  assign op   = frm_word[31:29];
  assign addr = frm_word[28:23];

  AST_BUSY_DROPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !frm_valid); // R11

  AST_BAD_LENGTH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != CW'(32)) |-> !frm_valid); // R12

  AST_HWCLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (dac_q == '0 && offset_q == '0)); // R10

  AST_LDAC_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_n && clr_n && !frm_valid) |=> dac_q == $past(inp_flat)); // R9

  AST_PUB_ALL_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && clr_n && op == 3'b010 && addr == 6'd63) |=> $stable(offset_q)); // R3

  AST_IDLE_OPS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && clr_n && ldac_n && (op == 3'b000 || op == 3'b101 || op == 3'b110))
    |=> ($stable(dac_q) && $stable(offset_q))); // R7

  AST_CLEAR_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && op == 3'b111) |=> busy); // R8
endmodule

bind mcdac_ctrl mcdac_ctrl_chk #(.NCH(NCH), .DW(DW), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n), .busy(busy),
  .frm_valid(frm_valid), .frm_word(frm_word), .cs_rise(cs_rise),
  .bit_cnt(bit_cnt), .dac_q(dac_q), .inp_flat(inp_flat), .offset_q(offset_q)
);

// File: tb/mcdac_ctrl_tb.sv
module mcdac_ctrl_tb;
  localparam int NCH = 32;
  localparam int DW  = 16;
  localparam int CLR_HOLD = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic dout, busy;
  logic [NCH*DW-1:0] dac_q;
  logic [DW-1:0] offset_q;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mcdac_ctrl #(.NCH(NCH), .DW(DW), .CLR_HOLD(CLR_HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .ldac_n(ldac_n), .clr_n(clr_n), .dout(dout), .busy(busy),
    .dac_q(dac_q), .offset_q(offset_q)
  );

  function automatic logic [31:0] cmd(input logic [2:0] op, input logic [5:0] a,
                                      input logic [15:0] d);
    return {op, a, 7'b0, d};
  endfunction

  function automatic logic [15:0] ch(input int k);
    return dac_q[k*DW +: DW];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer_n(input logic [31:0] w, input int n, output logic [31:0] rd);
    rd = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      din  = (i < 32) ? w[31-i] : 1'b0;
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      rd   = {rd[30:0], dout};
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] w, output logic [31:0] rd);
    xfer_n(w, 32, rd);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // {word[31:0], channel[5:0], expected channel[15:0], expected offset[15:0], req[3:0]}
  localparam int NROW = 18;
  localparam logic [73:0] TBL [NROW] = '{
    {3'b001, 6'd5,  7'd0, 16'h1234, 6'd5,  16'h0000, 16'h0000, 4'd2},  // R2
    {3'b010, 6'd5,  7'd0, 16'h0000, 6'd5,  16'h1234, 16'h0000, 4'd3},  // R3
    {3'b011, 6'd7,  7'd0, 16'hABCD, 6'd7,  16'hABCD, 16'h0000, 4'd4},  // R4
    {3'b001, 6'd32, 7'd0, 16'h4000, 6'd7,  16'hABCD, 16'h0000, 4'd2},  // R2
    {3'b010, 6'd32, 7'd0, 16'h0000, 6'd7,  16'hABCD, 16'h4000, 4'd3},  // R3
    {3'b001, 6'd63, 7'd0, 16'h55AA, 6'd5,  16'h1234, 16'h4000, 4'd13}, // R13
    {3'b010, 6'd63, 7'd0, 16'h0000, 6'd5,  16'h55AA, 16'h4000, 4'd3},  // R3
    {3'b000, 6'd5,  7'd0, 16'hFFFF, 6'd5,  16'h55AA, 16'h4000, 4'd7},  // R7
    {3'b101, 6'd5,  7'd0, 16'hFFFF, 6'd5,  16'h55AA, 16'h4000, 4'd7},  // R7
    {3'b110, 6'd63, 7'd0, 16'h0000, 6'd9,  16'h55AA, 16'h4000, 4'd7},  // R7
    {3'b011, 6'd63, 7'd0, 16'h0F0F, 6'd31, 16'h0F0F, 16'h4000, 4'd4},  // R4
    {3'b011, 6'd32, 7'd0, 16'h8000, 6'd31, 16'h0F0F, 16'h8000, 4'd4},  // R4
    {3'b111, 6'd31, 7'd0, 16'h0000, 6'd31, 16'h0000, 16'h8000, 4'd8},  // R8
    {3'b010, 6'd31, 7'd0, 16'h0000, 6'd31, 16'h0000, 16'h8000, 4'd8},  // R8
    {3'b001, 6'd32, 7'd0, 16'h2222, 6'd0,  16'h0F0F, 16'h8000, 4'd2},  // R2
    {3'b111, 6'd63, 7'd0, 16'h0000, 6'd0,  16'h0000, 16'h8000, 4'd8},  // R8
    {3'b010, 6'd32, 7'd0, 16'h0000, 6'd0,  16'h0000, 16'h2222, 4'd8},  // R8
    {3'b111, 6'd32, 7'd0, 16'h0000, 6'd0,  16'h0000, 16'h2222, 4'd8}   // R8
  };

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 dac_q zero", {31'b0, dac_q != '0}, 32'd0);
    chk("R1 offset zero", {16'b0, offset_q}, 32'd0);
    chk("R1 dout/busy zero", {30'b0, dout, busy}, 32'd0);

    for (int r = 0; r < NROW; r++) begin
      logic [73:0] row;
      row = TBL[r];
      wait_idle();
      xfer(row[73:42], rd);
      chk($sformatf("R%0d row %0d channel", row[3:0], r),
          {16'b0, ch(int'(row[41:36]))}, {16'b0, row[35:20]});
      chk($sformatf("R%0d row %0d offset", row[3:0], r),
          {16'b0, offset_q}, {16'b0, row[19:4]});
    end
    wait_idle();

    // R5 R6 configuration write and readback
    xfer(cmd(3'b001, 6'd33, 16'hC3A5), rd);
    xfer(cmd(3'b100, 6'd33, 16'h0000), rd);
    xfer(cmd(3'b000, 6'd0, 16'h0000), rd);
    chk("R5 config readback", rd, cmd(3'b100, 6'd33, 16'hC3A5));

    // R6 channel, offset and unused-address reads
    xfer(cmd(3'b011, 6'd3, 16'hBEEF), rd);
    chk("R4 ch3 write-through", {16'b0, ch(3)}, 32'h0000BEEF);
    xfer(cmd(3'b100, 6'd3, 16'h1111), rd);
    xfer(cmd(3'b100, 6'd32, 16'h0000), rd);
    chk("R6 ch3 readback", rd, cmd(3'b100, 6'd3, 16'hBEEF));
    xfer(cmd(3'b100, 6'd50, 16'h0000), rd);
    chk("R6 offset readback", rd, cmd(3'b100, 6'd32, 16'h2222));
    xfer(cmd(3'b000, 6'd0, 16'h0000), rd);
    chk("R6 unused address reads zero", rd, cmd(3'b100, 6'd50, 16'h0000));

    // R12 short and long frames discarded
    xfer_n(cmd(3'b011, 6'd2, 16'h1357), 31, rd);
    chk("R12 31-edge frame", {16'b0, ch(2)}, 32'd0);
    xfer_n(cmd(3'b011, 6'd2, 16'h1357), 33, rd);
    chk("R12 33-edge frame", {16'b0, ch(2)}, 32'd0);

    // R8 R11 clear, busy window, frame inside window ignored
    xfer(cmd(3'b011, 6'd1, 16'h1111), rd);
    chk("R4 ch1 preset", {16'b0, ch(1)}, 32'h00001111);
    xfer(cmd(3'b111, 6'd1, 16'h0000), rd);
    chk("R8 busy after clear", {31'b0, busy}, 32'd1);
    chk("R8 ch1 cleared", {16'b0, ch(1)}, 32'd0);
    xfer(cmd(3'b011, 6'd1, 16'h2222), rd);
    chk("R11 busy spans frame", {31'b0, busy}, 32'd1);
    wait_idle();
    chk("R11 frame in window dropped", {16'b0, ch(1)}, 32'd0);

    // R9 hardware load: channels follow staging, offset does not
    xfer(cmd(3'b001, 6'd4, 16'h7777), rd);
    xfer(cmd(3'b001, 6'd32, 16'h9999), rd);
    chk("R2 ch4 staged only", {16'b0, ch(4)}, 32'd0);
    ldac_n = 1'b0;
    repeat (2) @(negedge clk);
    ldac_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 ch4 loaded", {16'b0, ch(4)}, 32'h00007777);
    chk("R9 offset untouched", {16'b0, offset_q}, 32'h00002222);

    // R10 hardware clear wipes every register
    clr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 live zero during clear", {31'b0, dac_q != '0}, 32'd0);
    chk("R10 offset zero during clear", {16'b0, offset_q}, 32'd0);
    clr_n = 1'b1;
    wait_idle();
    xfer(cmd(3'b010, 6'd63, 16'h0000), rd);
    xfer(cmd(3'b010, 6'd32, 16'h0000), rd);
    chk("R10 ch4 staging cleared", {16'b0, ch(4)}, 32'd0);
    chk("R10 offset staging cleared", {16'b0, offset_q}, 32'd0);
    xfer(cmd(3'b100, 6'd33, 16'h0000), rd);
    xfer(cmd(3'b000, 6'd0, 16'h0000), rd);
    chk("R10 config cleared", rd, cmd(3'b100, 6'd33, 16'h0000));

    finish_run();
  end
endmodule